// File: doc/BRIEF.md
# External Pixel Port Clock Generator

This block drives an 8-bit pixel bus toward off-chip logic. It also drives a companion output clock, so that the outside logic can latch or demultiplex the bytes. The block runs on a core clock at twice the pixel rate. Every pixel occupies one slot of two core cycles. A slot starts on the first rising core edge after reset is released, and slots follow back to back from there. At each slot start the block does four things: it samples the pixel byte, the horizontal display-active flag and two configuration bits (clock enable and LCD mode), and it updates its registered outputs.

The output clock is a registered level and never a gated version of the core clock. It has three modes:
- **Off:** held at 0 to save power.
- **Pixel-rate:** one period per slot. It is low in the first half of the slot and high in the second, so its rising edge falls in the middle of a stable byte.
- **LCD:** a quarter-rate clock that runs only while display data is active. It is phase-locked to the start of each active period.

The bus only takes a new byte during active display. Outside active display it keeps its last value.

Top module: `ext_pixel_clkgen`

## Requirements
- R1: While `rst_n` is low, `ext_clk` and `ext_data` are 0 after every clock edge.
- R2: When the clock enable sampled at the slot start is 0, `ext_clk` is 0 in both halves of that slot, whatever the LCD-mode bit is.
- R3: When enable is 1 and LCD mode is 0, `ext_clk` is 0 in the first half of each slot and 1 in the second half. This gives one period per pixel at 50% duty.
- R4: When enable and LCD mode are both 1 during active display, the slots are counted 0,1,2,3 cyclically from the first active slot. `ext_clk` is 1 for the whole of slots 0 and 1 and 0 for slots 2 and 3. This gives a period of four pixels at 50% duty.
- R5: In LCD mode, `ext_clk` is 0 and does not toggle in any slot whose sampled display-active flag is 0.
- R6: Each new active period, meaning an active slot that follows an inactive slot, restarts the quarter-rate count at 0. The first active slot therefore drives `ext_clk` high.
- R7: At a slot start with display active, `ext_data` takes `pix_data`. At a slot start with display inactive, `ext_data` keeps its previous value. `ext_data` never changes mid-slot.
- R8: The configuration bits, the display flag and the pixel byte are sampled only at the slot start. Changes between slot starts have no effect on the outputs until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_data | input | 8 | Pixel byte for the current slot |
| disp_active | input | 1 | Horizontal display data is being output |
| cfg_clk_en | input | 1 | Output clock enable (0 = held low) |
| cfg_lcd_mode | input | 1 | 1 = quarter-rate LCD clock |
| ext_data | output | 8 | Registered pixel bus |
| ext_clk | output | 1 | Registered output clock |

## Verification
The stimulus starts with directed runs of steady display activity, one in each mode. In these runs the bench counts the high halves and rising edges of `ext_clk`, which separates a pixel-rate clock from a quarter-rate one and a correct duty cycle from a skewed one. After that, random slots mix short and long active periods with random configuration bits. They also change every input in the middle of each slot. The short bursts show whether the divider restarts at each new active period. The mid-slot changes show whether configuration or data leak in outside the slot start. A directed case with enable low and LCD mode high shows which of the two bits takes priority.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef enum logic [1:0] {
    CK_OFF = 2'd0,
    CK_PIX = 2'd1,
    CK_LCD = 2'd2
  } ck_mode_e;

  // Enable has priority: a disabled clock is low whatever the LCD bit says.
  function automatic ck_mode_e pick_mode(logic en, logic lcd);
    if (!en)     return CK_OFF;
    else if (lcd) return CK_LCD;
    else          return CK_PIX;
  endfunction

  // Output level for one half of a slot.
  function automatic logic ck_level(ck_mode_e m, logic second_half, logic lcd_hi);
    case (m)
      CK_PIX:  return second_half;
      CK_LCD:  return lcd_hi;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/epc_phase.sv
module epc_phase (
  input  logic clk,
  input  logic rst_n,
  output logic half_q,
  output logic slot_start
);
  // half_q = 0 means the coming edge opens a new slot.
  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign slot_start = ~half_q;
endmodule

// File: rtl/epc_cfg_latch.sv
module epc_cfg_latch
  import epc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     slot_start,
  input  logic     cfg_clk_en,
  input  logic     cfg_lcd_mode,
  output logic     en_q,
  output logic     lcd_q,
  output ck_mode_e mode_d
);
  logic en_d, lcd_d;

  always_comb begin
    en_d   = slot_start ? cfg_clk_en   : en_q;
    lcd_d  = slot_start ? cfg_lcd_mode : lcd_q;
    mode_d = pick_mode(en_d, lcd_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lcd_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      lcd_q <= lcd_d;
    end
  end
endmodule

// File: rtl/epc_lcd_div.sv
module epc_lcd_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic             disp_active,
  output logic             act_q,
  output logic [DIV_W-1:0] div_q,
  output logic             act_d,
  output logic             lcd_hi_d
);
  localparam logic [DIV_W-1:0] HALF = DIV_W'(1) << (DIV_W - 1);

  logic [DIV_W-1:0] div_d;

  always_comb begin
    act_d = slot_start ? disp_active : act_q;
    if (!slot_start)
      div_d = div_q;
    else if (disp_active && act_q)
      div_d = div_q + 1'b1;
    else
      div_d = '0;
    lcd_hi_d = act_d && (div_d < HALF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      div_q <= '0;
    end else begin
      act_q <= act_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/epc_data_reg.sv
module epc_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/ext_pixel_clkgen.sv
module ext_pixel_clkgen
  import epc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              disp_active,
  input  logic              cfg_clk_en,
  input  logic              cfg_lcd_mode,
  output logic [DATA_W-1:0] ext_data,
  output logic              ext_clk
);
  logic             half_q, slot_start;
  logic             en_q, lcd_q;
  ck_mode_e         mode_d;
  logic             act_q, act_d, lcd_hi_d;
  logic [DIV_W-1:0] div_q;
  logic             data_load;
  logic             ck_d;

  epc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .half_q(half_q), .slot_start(slot_start)
  );

  epc_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .cfg_clk_en(cfg_clk_en), .cfg_lcd_mode(cfg_lcd_mode),
    .en_q(en_q), .lcd_q(lcd_q), .mode_d(mode_d)
  );

  epc_lcd_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .disp_active(disp_active), .act_q(act_q), .div_q(div_q),
    .act_d(act_d), .lcd_hi_d(lcd_hi_d)
  );

  assign data_load = slot_start && disp_active;

  epc_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .load(data_load), .din(pix_data), .dout(ext_data)
  );

  // First half of the slot is produced at the slot-start edge.
  assign ck_d = ck_level(mode_d, ~slot_start, lcd_hi_d && act_d);

  always_ff @(posedge clk) begin
    if (!rst_n) ext_clk <= 1'b0;
    else        ext_clk <= ck_d;
  end
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_active,
  input logic              ext_clk,
  input logic [DATA_W-1:0] ext_data,
  input logic              half_q,
  input logic              en_q,
  input logic              lcd_q,
  input logic              act_q,
  input logic [DIV_W-1:0]  div_q
);
  // R2
  clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !ext_clk);

  // R3
  pix_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !lcd_q) |-> (ext_clk == !half_q));

  // R5
  lcd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && lcd_q && !act_q) |-> !ext_clk);

  // R4
  div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_q && act_q && disp_active) |=> (div_q == DIV_W'($past(div_q) + 1'b1)));

  // R6
  div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_q && !act_q && disp_active) |=> (act_q && div_q == '0));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q || !disp_active) |=> $stable(ext_data));

  // R8
  cfg_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |=> ($stable(en_q) && $stable(lcd_q) && $stable(act_q)));
endmodule

bind ext_pixel_clkgen epc_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W)) chk (
  .clk(clk), .rst_n(rst_n), .disp_active(disp_active), .ext_clk(ext_clk),
  .ext_data(ext_data), .half_q(half_q), .en_q(en_q), .lcd_q(lcd_q),
  .act_q(act_q), .div_q(div_q)
);

// File: tb/ext_pixel_clkgen_test.sv
module ext_pixel_clkgen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pix_data;
  logic       disp_active, cfg_clk_en, cfg_lcd_mode;
  logic [7:0] ext_data;
  logic       ext_clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic       m_en, m_lcd, m_act;
  logic [1:0] m_div;
  logic [7:0] m_data;
  int         hi_cnt, rise_cnt;
  logic       prev_ck;

  always #2.5 clk = ~clk;

  ext_pixel_clkgen uut (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .disp_active(disp_active),
    .cfg_clk_en(cfg_clk_en), .cfg_lcd_mode(cfg_lcd_mode),
    .ext_data(ext_data), .ext_clk(ext_clk)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_ck(logic en, logic lcd, logic act, logic [1:0] dv, logic second);
    if (!en) return 1'b0;
    if (lcd) return act && (dv <= 2'd1);
    return second;
  endfunction

  function automatic string ck_req(logic en, logic lcd, logic act);
    if (!en) return "R2";
    if (!lcd) return "R3";
    return act ? "R4" : "R5";
  endfunction

  task automatic track(logic v);
    if (v) hi_cnt++;
    if (v && !prev_ck) rise_cnt++;
    prev_ck = v;
  endtask

  // One slot: drive at a negedge, check after the slot-start edge and the mid edge.
  task automatic slot(logic [7:0] d, logic act, logic en, logic lcd, logic mid_scramble);
    pix_data = d; disp_active = act; cfg_clk_en = en; cfg_lcd_mode = lcd;
    m_div = (act && m_act) ? m_div + 2'd1 : 2'd0;
    m_act = act; m_en = en; m_lcd = lcd;
    if (act) m_data = d;
    @(negedge clk);
    chk("R7", ext_data, m_data);
    chk(ck_req(m_en, m_lcd, m_act), ext_clk, exp_ck(m_en, m_lcd, m_act, m_div, 1'b0));
    track(ext_clk);
    if (mid_scramble) begin  // R8: mid-slot changes must be ignored
      pix_data = ~d; disp_active = ~act; cfg_clk_en = ~en; cfg_lcd_mode = ~lcd;
    end
    @(negedge clk);
    chk("R8", ext_data, m_data);
    chk(mid_scramble ? "R8" : ck_req(m_en, m_lcd, m_act), ext_clk,
        exp_ck(m_en, m_lcd, m_act, m_div, 1'b1));
    track(ext_clk);
  endtask

  task automatic clr_meas();
    hi_cnt = 0; rise_cnt = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pix_data = 8'hA5; disp_active = 1'b1;
    cfg_clk_en = 1'b1; cfg_lcd_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", ext_clk, 0);
    chk("R1", ext_data, 0);
    m_en = 0; m_lcd = 0; m_act = 0; m_div = 0; m_data = 0; prev_ck = 0;
    rst_n = 1'b1;

    // Pixel-rate mode: one rise per slot, half duty (R3)
    clr_meas();
    for (int i = 0; i < 10; i++) slot(8'(i * 7 + 1), 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3", rise_cnt, 10);
    chk("R3", hi_cnt, 10);

    // LCD inactive: no toggles (R5)
    slot(8'h11, 1'b0, 1'b1, 1'b1, 1'b0);
    clr_meas();
    for (int i = 0; i < 10; i++) slot(8'h22, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R5", rise_cnt, 0);
    chk("R7", ext_data, m_data);

    // LCD active run: period four slots, duty half (R4, R6)
    clr_meas();
    for (int i = 0; i < 16; i++) slot(8'(i + 8'h40), 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R4", rise_cnt, 4);
    chk("R4", hi_cnt, 16);

    // Short bursts restart the divider (R6)
    for (int b = 0; b < 4; b++) begin
      slot(8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
      slot(8'(b), 1'b1, 1'b1, 1'b1, 1'b0);
      chk("R6", ext_clk, 1);
      slot(8'(b + 9), 1'b1, 1'b1, 1'b1, 1'b0);
    end

    // Enable low beats LCD bit (R2)
    clr_meas();
    for (int i = 0; i < 6; i++) slot(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R2", rise_cnt, 0);

    // Mid-slot scrambling in each mode (R8)
    for (int i = 0; i < 8; i++) slot(8'(i * 3), 1'(i % 2), 1'b1, 1'(i / 4), 1'b1);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic a;
      a = ($urandom % 8) < 6 ? m_act : ~m_act;
      slot(8'($urandom), a, ($urandom % 5) != 0, ($urandom % 2) == 1, ($urandom % 3) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule